// File: doc/BRIEF.md
# Multi-Rate Serial Lane

This block is a set of independent serial lanes. Each lane has a transmit half, which turns an 8-bit parallel word into a serial bit stream, and a receive half, which collects serial bits back into an 8-bit word. Each lane runs at full, half or quarter line rate. At full rate all eight bits of the word travel in one reference period. At half rate only the upper four bits travel, and at quarter rate only the upper two. The lower bits of the bus are then unused. The design does no framing and no scrambling, so the data crosses the lane unchanged. Keeping enough ones on the line for clock recovery is the job of the user logic.

A single fast clock `clk` stands for the bit clock. The shared input `word_stb` marks the start of each reference period, and the bench pulses it once every 8 clocks. A slower rate holds each serial bit for 2 clocks (half rate) or 4 clocks (quarter rate), so the amount of data per reference period shrinks in proportion. Each lane takes its rate setting at the strobe, so different lanes can use different rates at the same time.

Top module: `serlane_top`

## Requirements
- R1: With rate code 00 (full rate), after a strobe edge `ser_out` presents word bits 7 down to 0. Each bit is held for one clock, and bit 7 is visible in the first cycle after the strobe.
- R2: With rate code 01 (half rate), `ser_out` presents bits 7, 6, 5 and 4, each held for two clocks. Bits 3:0 of the transmit word are never sent.
- R3: With rate code 10 (quarter rate), `ser_out` presents bits 7 and 6, each held for four clocks. Bits 5:0 of the transmit word are never sent.
- R4: Rate code 11 behaves exactly like full rate on both the transmit and the receive side.
- R5: A lane samples its rate code and transmit word only at a strobe edge. Changes to either input between strobes have no effect on the word already in flight.
- R6: Each lane has its own rate code, and lanes running at full, half and quarter rate at the same time do not affect one another.
- R7: The receive side puts each received bit back into the bit position it was sent from. Bits 3:0 (half rate) or bits 5:0 (quarter rate) of `rx_word` read zero.
- R8: `rx_valid` pulses for one cycle, in the cycle after a strobe edge, when at least 8 clocks have passed since the previous strobe. It does not pulse on the first strobe after reset or on a strobe that comes early. `rx_word` holds its value between pulses.
- R9: A synchronous active-high reset drives `ser_out`, `rx_valid` and `rx_word` to zero. The reset state holds until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb | input | 1 | One-cycle marker of each reference period, shared by all lanes |
| rate_sel | input | 2*NUM_CH | Per-lane rate code: 00 full, 01 half, 10 quarter, 11 full |
| tx_word | input | 8*NUM_CH | Per-lane parallel transmit word |
| ser_out | output | NUM_CH | Per-lane serial output, MSB first |
| ser_in | input | NUM_CH | Per-lane serial input |
| rx_word | output | 8*NUM_CH | Per-lane reassembled word |
| rx_valid | output | NUM_CH | Per-lane word-complete pulse |

## Verification
The hardest case to reach is a rate code that changes partway through a word. The design must then keep the old rate until the word ends, and only the next word may use the new one. The stimulus loops every `ser_out` back into its `ser_in`. It then changes `rate_sel` and `tx_word` in the clocks between strobes, while all three lanes run different rates. Every serial bit and every reassembled word is compared against the settings captured at the strobe. Other sequences put an early strobe and a reset in the middle of traffic, so that the rules for `rx_valid` are tested in both cases.

// File: rtl/serlane_pkg.sv
package serlane_pkg;
  typedef enum logic [1:0] {
    RATE_FULL = 2'b00,
    RATE_HALF = 2'b01,
    RATE_QTR  = 2'b10,
    RATE_ALT  = 2'b11
  } rate_e;

  // Low phase-counter bits that must all be one to close a bit slot.
  function automatic logic [1:0] slot_mask(input rate_e r);
    case (r)
      RATE_HALF: slot_mask = 2'b01;
      RATE_QTR:  slot_mask = 2'b11;
      default:   slot_mask = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/serlane_tx.sv
module serlane_tx
  import serlane_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [1:0]        rate,
  input  logic [WORD_W-1:0] word,
  output logic              ser
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  rate_e             rate_q;
  logic [1:0]        msk;

  assign msk = slot_mask(rate_q);
  assign ser = sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      cnt    <= '0;
      rate_q <= RATE_FULL;
    end else if (stb) begin
      sh     <= word;
      cnt    <= '0;
      rate_q <= rate_e'(rate);
    end else begin
      if ((cnt[1:0] & msk) == msk) sh <= {sh[WORD_W-2:0], 1'b0};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  // R5: rate held for the whole word
  assert_rate_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(rate_q));
  // R3: quarter-rate bit spans four clocks
  assert_qtr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!stb && rate_q == RATE_QTR && cnt[1:0] != 2'b11) |=> $stable(ser));
endmodule

// File: rtl/serlane_rx.sv
module serlane_rx
  import serlane_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [1:0]        rate,
  input  logic              ser,
  output logic [WORD_W-1:0] word_out,
  output logic              valid
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W - 1);
  localparam int HALF_W = WORD_W / 2;
  localparam int QTR_W  = WORD_W / 4;

  logic [WORD_W-2:0] acc;
  logic [CNT_W-1:0]  cnt;
  rate_e             rate_q;
  logic              armed;
  logic [1:0]        msk;
  logic [WORD_W-1:0] gathered;

  assign msk = slot_mask(rate_q);

  always_comb begin
    case (rate_q)
      RATE_HALF: gathered = {acc[HALF_W-2:0], ser, {(WORD_W-HALF_W){1'b0}}};
      RATE_QTR:  gathered = {acc[QTR_W-2:0], ser, {(WORD_W-QTR_W){1'b0}}};
      default:   gathered = {acc, ser};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      cnt      <= '0;
      rate_q   <= RATE_FULL;
      armed    <= 1'b0;
      valid    <= 1'b0;
      word_out <= '0;
    end else begin
      valid <= 1'b0;
      if (stb) begin
        if (armed && cnt == CNT_MAX) begin
          word_out <= gathered;
          valid    <= 1'b1;
        end
        acc    <= '0;
        cnt    <= '0;
        rate_q <= rate_e'(rate);
        armed  <= 1'b1;
      end else if (cnt != CNT_MAX) begin
        if ((cnt[1:0] & msk) == msk) acc <= {acc[WORD_W-3:0], ser};
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8: completion pulse only right after a strobe
  assert_valid_after_stb_R8: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(stb));
  // R7: unused low bits cleared at reduced rates
  assert_half_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(rate_q) == RATE_HALF) |-> word_out[HALF_W-1:0] == '0);
  assert_qtr_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(rate_q) == RATE_QTR) |-> word_out[WORD_W-QTR_W-1:0] == '0);
endmodule

// File: rtl/serlane_top.sv
module serlane_top #(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     word_stb,
  input  logic [2*NUM_CH-1:0]      rate_sel,
  input  logic [WORD_W*NUM_CH-1:0] tx_word,
  output logic [NUM_CH-1:0]        ser_out,
  input  logic [NUM_CH-1:0]        ser_in,
  output logic [WORD_W*NUM_CH-1:0] rx_word,
  output logic [NUM_CH-1:0]        rx_valid
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    serlane_tx #(.WORD_W(WORD_W)) u_tx (
      .clk  (clk),
      .rst  (rst),
      .stb  (word_stb),
      .rate (rate_sel[2*ch +: 2]),
      .word (tx_word[WORD_W*ch +: WORD_W]),
      .ser  (ser_out[ch])
    );
    serlane_rx #(.WORD_W(WORD_W)) u_rx (
      .clk      (clk),
      .rst      (rst),
      .stb      (word_stb),
      .rate     (rate_sel[2*ch +: 2]),
      .ser      (ser_in[ch]),
      .word_out (rx_word[WORD_W*ch +: WORD_W]),
      .valid    (rx_valid[ch])
    );
  end
endmodule

// File: tb/sim_serlane_top.sv
module sim_serlane_top;
  localparam int NCH = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst = 1'b1;
  logic            word_stb = 1'b0;
  logic [2*NCH-1:0] rate_sel = '0;
  logic [8*NCH-1:0] tx_word = '0;
  wire  [NCH-1:0]   ser_out;
  wire  [NCH-1:0]   ser_in;
  wire  [8*NCH-1:0] rx_word;
  wire  [NCH-1:0]   rx_valid;

  assign ser_in = ser_out;

  serlane_top #(.NUM_CH(NCH), .WORD_W(8)) u0 (
    .clk(clk), .rst(rst), .word_stb(word_stb), .rate_sel(rate_sel),
    .tx_word(tx_word), .ser_out(ser_out), .ser_in(ser_in),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string phase = "R9";

  // behavioural reference
  int       m_k[NCH];
  int       m_len[NCH];
  bit       m_seen[NCH];
  logic [7:0] m_w[NCH];
  bit       e_v[NCH];
  logic [7:0] e_w[NCH];

  function automatic int slot_len(input logic [1:0] code);
    if (code == 2'b01) return 2;
    if (code == 2'b10) return 4;
    return 1;
  endfunction

  function automatic logic [7:0] keep_mask(input int len);
    if (len == 2) return 8'hF0;
    if (len == 4) return 8'hC0;
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    for (int ch = 0; ch < NCH; ch++) begin
      if (rst) begin
        m_k[ch] = 0; m_len[ch] = 1; m_seen[ch] = 0; m_w[ch] = 8'h00;
        e_v[ch] = 0; e_w[ch] = 8'h00;
      end else if (word_stb) begin
        e_v[ch] = m_seen[ch] && (m_k[ch] >= 7);
        if (e_v[ch]) e_w[ch] = m_w[ch] & keep_mask(m_len[ch]);
        m_w[ch]   = tx_word[8*ch +: 8];
        m_len[ch] = slot_len(rate_sel[2*ch +: 2]);
        m_k[ch]   = 0;
        m_seen[ch] = 1;
      end else begin
        e_v[ch] = 0;
        if (m_k[ch] < 1000) m_k[ch]++;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s/%s at %0t: actual %0h expected %0h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int ch = 0; ch < NCH; ch++) begin
        string tag;
        tag = (m_len[ch] == 1) ? "R1" : (m_len[ch] == 2) ? "R2" : "R3";
        if (!m_seen[ch]) check("R9", int'(ser_out[ch]), 0);
        else if (m_k[ch] < 8)
          check(tag, int'(ser_out[ch]), int'(m_w[ch][7 - m_k[ch] / m_len[ch]]));
        check("R8", int'(rx_valid[ch]), int'(e_v[ch]));
        check("R7", int'(rx_word[8*ch +: 8]), int'(e_w[ch]));
      end
    end
  end

  // one reference period: strobe then gap-1 quiet clocks; optional mid-word input change
  task automatic period(input logic [5:0] rates, input logic [23:0] words, input int gap,
                        input bit disturb);
    @(negedge clk); #1;
    word_stb = 1'b1; rate_sel = rates; tx_word = words;
    @(negedge clk); #1;
    word_stb = 1'b0;
    if (disturb) begin rate_sel = ~rates; tx_word = ~words; end
    for (int i = 1; i < gap - 1; i++) @(negedge clk);
    if (gap > 1) #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    repeat (4) @(negedge clk);
    phase = "R1";
    period(6'b000000, 24'hA5_3C_81, 8, 0);
    period(6'b000000, 24'h7E_00_FF, 8, 0);
    period(6'b000000, 24'h96_C3_18, 8, 0);
    phase = "R2";
    period(6'b010101, 24'hBE_5F_A9, 8, 0);
    period(6'b010101, 24'h6D_93_F7, 8, 0);
    phase = "R3";
    period(6'b101010, 24'h7F_BF_C5, 8, 0);
    period(6'b101010, 24'h3A_E6_9C, 8, 0);
    phase = "R4";
    period(6'b111111, 24'h5A_E1_2D, 8, 0);
    period(6'b111111, 24'hC9_47_B8, 8, 0);
    phase = "R6";
    period(6'b100100, 24'hD3_6B_F1, 8, 0);
    period(6'b001001, 24'h4C_B7_2E, 8, 0);
    period(6'b010010, 24'hE8_19_A7, 8, 0);
    phase = "R5";
    period(6'b100100, 24'h9B_F4_63, 8, 1);
    period(6'b011000, 24'h2F_C8_D5, 8, 1);
    period(6'b000110, 24'hA7_5E_3B, 8, 1);
    phase = "R8";
    period(6'b000000, 24'h11_22_33, 5, 0);
    period(6'b010100, 24'hF0_0F_AA, 8, 0);
    period(6'b000000, 24'h55_CC_E7, 8, 0);
    phase = "R9";
    @(negedge clk); #1 rst = 1'b1;
    @(negedge clk); #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    period(6'b000000, 24'h81_42_24, 8, 0);
    period(6'b100001, 24'hFF_FF_FF, 8, 0);
    period(6'b000000, 24'h00_00_00, 8, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule